// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

This block is a synchronous true dual-port memory, 8K words of 8 bits by default, shared by two agents called the left port and the right port. Each port has its own enable, write select, address, write data and read data, and each can read or write any word in any cycle, independently of the other. Reads are registered: the data addressed in one cycle is presented after the next rising clock edge and is held until the port reads again.

The two highest words double as mailboxes. When one port writes the mailbox that belongs to the other side, that side's active-low interrupt output goes low; the receiving port clears it by reading its own mailbox. The mailbox payload is ordinary memory data. Setting the parameter `MBOX_EN` to 0 turns the two words into plain storage and keeps both interrupt outputs high. Arbitration between colliding ports is not part of this block.

Top module: `dpr_mbox_top`

## Requirements
- R1: A write (enable 1, write select 1) stores the data at the rising edge; a later read (enable 1, write select 0) of that address from either port returns it.
- R2: Read data appears one clock after the read is presented and holds its value in every cycle the port does not read.
- R3: A read that occurs in the same cycle as a write to that address by the other port returns the value held before the write.
- R4: A right-port write to address 0x1FFE drives `lp_irq_n` low from the next clock edge on.
- R5: A left-port read of address 0x1FFE returns `lp_irq_n` high from the next clock edge on.
- R6: A left-port write to address 0x1FFF drives `rp_irq_n` low from the next clock edge on.
- R7: A right-port read of address 0x1FFF returns `rp_irq_n` high from the next clock edge on.
- R8: Mailbox words store and return data like any other word; a read by the sending port neither sets nor clears a flag.
- R9: A port with enable 0 neither reads, writes, sets nor clears a flag; its read data holds.
- R10: When a set and a clear of one flag fall in the same cycle, the flag ends up set.
- R11: During synchronous active-low reset both interrupt outputs go high and both read data outputs go to zero after the edge.
- R12: With `MBOX_EN` = 0 both interrupt outputs stay high and 0x1FFE/0x1FFF act as plain memory.
- R13: When both ports write one address in the same cycle, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| lp_en | input | 1 | Left port access enable |
| lp_we | input | 1 | Left port write select (1 write, 0 read) |
| lp_addr | input | ADDR_W | Left port word address |
| lp_wdata | input | DATA_W | Left port write data |
| lp_rdata | output | DATA_W | Left port registered read data |
| lp_irq_n | output | 1 | Left interrupt, active low |
| rp_en | input | 1 | Right port access enable |
| rp_we | input | 1 | Right port write select (1 write, 0 read) |
| rp_addr | input | ADDR_W | Right port word address |
| rp_wdata | input | DATA_W | Right port write data |
| rp_rdata | output | DATA_W | Right port registered read data |
| rp_irq_n | output | 1 | Right interrupt, active low |

## Verification
Every result of this block is due exactly one clock edge after the access that causes it: read data, the fall of an interrupt after a mailbox write and its rise after the clearing read. The bench drives each access just after a falling edge, advances a behavioural model at the rising edge, and compares both read buses and both interrupts with the model at the following falling edge, so each comparison lands on the first cycle a result is due and every later cycle also confirms that it holds. A second instance with the mailbox function off receives the same stimulus and is compared against plain-memory expectations.

// File: rtl/dpr_pkg.sv
// Package: shared definitions for the dual-port mailbox memory.
// Assumes: addresses and data are plain unsigned vectors sized by the top.
package dpr_pkg;

    // Kind of access one port performs in a cycle.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    // Classify one port's control pins into an access kind.
    function automatic acc_e classify(input logic en, input logic we);
        if (!en)     return ACC_IDLE;
        else if (we) return ACC_WRITE;
        else         return ACC_READ;
    endfunction

endpackage

// File: rtl/dpr_port_dec.sv
// Module: per-port access decoder.
// Turns enable/write-select/address into read and write strobes, and flags
// a read of this port's own mailbox (clear) or a write of the opposite
// port's mailbox (set). Assumes OWN_BOX and FAR_BOX fit in ADDR_W bits.
module dpr_port_dec
    import dpr_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int OWN_BOX = 8190,
    parameter int FAR_BOX = 8191
) (
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_en,
    output logic              wr_en,
    output logic              own_box_rd,
    output logic              far_box_wr
);
    localparam logic [ADDR_W-1:0] OWN_A = ADDR_W'(OWN_BOX);
    localparam logic [ADDR_W-1:0] FAR_A = ADDR_W'(FAR_BOX);

    acc_e kind;

    // Decode the access kind and the mailbox hits.
    always_comb begin
        kind       = classify(en, we);
        rd_en      = (kind == ACC_READ);
        wr_en      = (kind == ACC_WRITE);
        own_box_rd = rd_en && (addr == OWN_A);
        far_box_wr = wr_en && (addr == FAR_A);
    end

    // R9: an idle port produces no strobe of any kind.
    always_comb begin
        a_idle_quiet_r9: assert (en || !(rd_en || wr_en || own_box_rd || far_box_wr));
    end

endmodule

// File: rtl/dpr_store.sv
// Module: two-port storage array with registered read data.
// Assumes: both ports share clk; on a same-address double write port A wins;
// a read sees the contents from before this cycle's writes. The array
// itself is not reset; only the read registers are.
module dpr_store #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic              a_re,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_we,
    input  logic              b_re,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Array update: port B first so that port A overrides on a tie.
    always_ff @(posedge clk) begin
        if (b_we) mem[b_addr] <= b_wdata;
        if (a_we) mem[a_addr] <= a_wdata;
    end

    // Port A read register, loaded only on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)    a_rdata <= '0;
        else if (a_re) a_rdata <= mem[a_addr];
    end

    // Port B read register, loaded only on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)    b_rdata <= '0;
        else if (b_re) b_rdata <= mem[b_addr];
    end

    // R2: no read, no change.
    p_hold_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !a_re |=> $stable(a_rdata));
    p_hold_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !b_re |=> $stable(b_rdata));

    // R1: a lone write followed by a read of that word returns the data.
    p_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (a_re && $past(a_we && !b_we) && (a_addr == $past(a_addr)))
        |=> (a_rdata == $past(a_wdata, 2)));

    // R11: reset clears the read registers.
    p_rst_rd_r11: assert property (@(posedge clk)
        !rst_n |=> (a_rdata == '0 && b_rdata == '0));

endmodule

// File: rtl/dpr_mbox_flag.sv
// Module: one mailbox interrupt flag.
// Set by the sending port's mailbox write, cleared by the receiving port's
// mailbox read; set takes priority. Synchronous active-low reset to clear.
module dpr_mbox_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);
    // Flag register with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);
    p_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q);
    p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_q));
    p_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && clr_i) |=> flag_q);
    p_rst_r11: assert property (@(posedge clk)
        !rst_n |=> !flag_q);

endmodule

// File: rtl/dpr_mbox_top.sv
// Module: dual-port memory with cross-port mailbox interrupts (top).
// Assumes one clock for both ports and a synchronous active-low reset.
// The two highest words are mailboxes when MBOX_EN is 1: the second-highest
// belongs to the left port, the highest to the right port.
module dpr_mbox_top #(
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 8,
    parameter bit MBOX_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_en,
    input  logic              lp_we,
    input  logic [ADDR_W-1:0] lp_addr,
    input  logic [DATA_W-1:0] lp_wdata,
    output logic [DATA_W-1:0] lp_rdata,
    output logic              lp_irq_n,
    input  logic              rp_en,
    input  logic              rp_we,
    input  logic [ADDR_W-1:0] rp_addr,
    input  logic [DATA_W-1:0] rp_wdata,
    output logic [DATA_W-1:0] rp_rdata,
    output logic              rp_irq_n
);
    localparam int LEFT_BOX  = (1 << ADDR_W) - 2;
    localparam int RIGHT_BOX = (1 << ADDR_W) - 1;

    logic l_rd, l_wr, l_clr, l_set_far;
    logic r_rd, r_wr, r_clr, r_set_far;
    logic l_flag, r_flag;

    dpr_port_dec #(.ADDR_W(ADDR_W), .OWN_BOX(LEFT_BOX), .FAR_BOX(RIGHT_BOX)) u_ldec (
        .en(lp_en), .we(lp_we), .addr(lp_addr),
        .rd_en(l_rd), .wr_en(l_wr), .own_box_rd(l_clr), .far_box_wr(l_set_far)
    );

    dpr_port_dec #(.ADDR_W(ADDR_W), .OWN_BOX(RIGHT_BOX), .FAR_BOX(LEFT_BOX)) u_rdec (
        .en(rp_en), .we(rp_we), .addr(rp_addr),
        .rd_en(r_rd), .wr_en(r_wr), .own_box_rd(r_clr), .far_box_wr(r_set_far)
    );

    dpr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_we(l_wr), .a_re(l_rd), .a_addr(lp_addr), .a_wdata(lp_wdata), .a_rdata(lp_rdata),
        .b_we(r_wr), .b_re(r_rd), .b_addr(rp_addr), .b_wdata(rp_wdata), .b_rdata(rp_rdata)
    );

    generate
        if (MBOX_EN) begin : g_mbox
            // Left flag: set by the right port, cleared by the left port.
            dpr_mbox_flag u_lflag (
                .clk(clk), .rst_n(rst_n), .set_i(r_set_far), .clr_i(l_clr), .flag_q(l_flag)
            );
            // Right flag: set by the left port, cleared by the right port.
            dpr_mbox_flag u_rflag (
                .clk(clk), .rst_n(rst_n), .set_i(l_set_far), .clr_i(r_clr), .flag_q(r_flag)
            );
        end else begin : g_plain
            assign l_flag = 1'b0;
            assign r_flag = 1'b0;

            // R12: with mailboxes off no interrupt ever shows.
            p_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
                lp_irq_n && rp_irq_n);
        end
    endgenerate

    // Active-low interrupt outputs.
    assign lp_irq_n = ~l_flag;
    assign rp_irq_n = ~r_flag;

    // R9: a disabled port keeps its read data.
    p_idle_l_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lp_en |=> $stable(lp_rdata));
    p_idle_r_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rp_en |=> $stable(rp_rdata));

    // R6/R7 seen at the pins: a left write of the right mailbox lowers rp_irq_n.
    p_rset_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (MBOX_EN && lp_en && lp_we && lp_addr == ADDR_W'(RIGHT_BOX)) |=> !rp_irq_n);

endmodule

// File: tb/sim_dpr_mbox_top.sv
// Bench: behavioural reference model compared with two instances every cycle.
module sim_dpr_mbox_top;
    localparam int AW = 13;
    localparam int DW = 8;
    localparam int LBOX = 8190;
    localparam int RBOX = 8191;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic le = 0, lw = 0, re = 0, rw = 0;
    logic [AW-1:0] la = '0, ra = '0;
    logic [DW-1:0] ld = '0, rd = '0;
    logic [DW-1:0] l_q0, r_q0, l_q1, r_q1;
    logic li0, ri0, li1, ri1;

    int nchk = 0;
    int nfail = 0;
    string cur_req = "R11";

    always #4 clk = ~clk;

    dpr_mbox_top #(.ADDR_W(AW), .DATA_W(DW), .MBOX_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n),
        .lp_en(le), .lp_we(lw), .lp_addr(la), .lp_wdata(ld), .lp_rdata(l_q0), .lp_irq_n(li0),
        .rp_en(re), .rp_we(rw), .rp_addr(ra), .rp_wdata(rd), .rp_rdata(r_q0), .rp_irq_n(ri0)
    );

    dpr_mbox_top #(.ADDR_W(AW), .DATA_W(DW), .MBOX_EN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n),
        .lp_en(le), .lp_we(lw), .lp_addr(la), .lp_wdata(ld), .lp_rdata(l_q1), .lp_irq_n(li1),
        .rp_en(re), .rp_we(rw), .rp_addr(ra), .rp_wdata(rd), .rp_rdata(r_q1), .rp_irq_n(ri1)
    );

    // Reference model state.
    logic [DW-1:0] mm [int];
    logic [DW-1:0] lq_m = '0, rq_m = '0;
    bit lq_k = 0, rq_k = 0, fl_m = 0, fr_m = 0, live = 0;

    // Model advance at each rising edge from the inputs applied before it.
    always @(posedge clk) begin
        if (!rst_n) begin
            lq_m = '0; rq_m = '0; lq_k = 1; rq_k = 1; fl_m = 0; fr_m = 0; live = 1;
        end else begin
            bit sl, cl, sr, cr;
            if (le && !lw) begin
                lq_k = mm.exists(int'(la));
                if (lq_k) lq_m = mm[int'(la)];
            end
            if (re && !rw) begin
                rq_k = mm.exists(int'(ra));
                if (rq_k) rq_m = mm[int'(ra)];
            end
            sl = re && rw && (int'(ra) == LBOX);
            cl = le && !lw && (int'(la) == LBOX);
            sr = le && lw && (int'(la) == RBOX);
            cr = re && !rw && (int'(ra) == RBOX);
            fl_m = sl ? 1'b1 : (cl ? 1'b0 : fl_m);
            fr_m = sr ? 1'b1 : (cr ? 1'b0 : fr_m);
            if (re && rw) mm[int'(ra)] = rd;
            if (le && lw) mm[int'(la)] = ld;
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare both instances with the model.
    task automatic compare();
        if (!live) return;
        chk(cur_req, "lp_irq_n", int'(li0), int'(!fl_m));
        chk(cur_req, "rp_irq_n", int'(ri0), int'(!fr_m));
        if (lq_k) chk(cur_req, "lp_rdata", int'(l_q0), int'(lq_m));
        if (rq_k) chk(cur_req, "rp_rdata", int'(r_q0), int'(rq_m));
        chk("R12", "u1 lp_irq_n", int'(li1), 1);
        chk("R12", "u1 rp_irq_n", int'(ri1), 1);
        if (lq_k) chk("R12", "u1 lp_rdata", int'(l_q1), int'(lq_m));
        if (rq_k) chk("R12", "u1 rp_rdata", int'(r_q1), int'(rq_m));
    endtask

    task automatic step(bit e0, bit w0, int a0, int d0, bit e1, bit w1, int a1, int d1, string tag);
        @(negedge clk);
        compare();
        cur_req = tag;
        le = e0; lw = w0; la = AW'(a0); ld = DW'(d0);
        re = e1; rw = w1; ra = AW'(a1); rd = DW'(d1);
    endtask

    task automatic idle(string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        idle("R11");
        idle("R11");
        rst_n = 1'b1;
        idle("R11");
        // R1: each port writes, then each reads the other's word
        step(1, 1, 16, 'hA5, 1, 1, 32, 'h3C, "R1");
        step(1, 0, 32, 0, 1, 0, 16, 0, "R1");
        // R2: hold without reads
        idle("R2");
        step(1, 1, 17, 'h77, 1, 1, 33, 'h66, "R2");
        idle("R2");
        // R3: read during the other port's write gets old data
        step(1, 1, 48, 'h11, 0, 0, 0, 0, "R3");
        step(1, 1, 48, 'h22, 1, 0, 48, 0, "R3");
        step(0, 0, 0, 0, 1, 0, 48, 0, "R3");
        // R4: right writes the left mailbox
        step(0, 0, 0, 0, 1, 1, LBOX, 'h5A, "R4");
        idle("R4");
        // R8: sender reads the mailbox; data returned, flag unchanged
        step(0, 0, 0, 0, 1, 0, LBOX, 0, "R8");
        // R5: receiver reads and clears
        step(1, 0, LBOX, 0, 0, 0, 0, 0, "R5");
        idle("R5");
        // R6: left writes the right mailbox
        step(1, 1, RBOX, 'hC3, 0, 0, 0, 0, "R6");
        idle("R6");
        // R9: disabled ports touch nothing
        step(0, 0, RBOX, 0, 0, 0, RBOX, 0, "R9");
        step(0, 1, RBOX, 'h99, 0, 1, LBOX, 'h98, "R9");
        step(1, 0, RBOX, 0, 0, 0, 0, 0, "R9");
        // R7: receiver reads and clears
        step(0, 0, 0, 0, 1, 0, RBOX, 0, "R7");
        idle("R7");
        // R10: set and clear together
        step(0, 0, 0, 0, 1, 1, LBOX, 'h01, "R10");
        step(1, 0, LBOX, 0, 1, 1, LBOX, 'h02, "R10");
        idle("R10");
        step(1, 0, LBOX, 0, 0, 0, 0, 0, "R10");
        // R13: double write, left wins
        step(1, 1, 64, 'hAB, 1, 1, 64, 'hCD, "R13");
        step(1, 0, 64, 0, 1, 0, 64, 0, "R13");
        idle("R13");
        // R1: mixed traffic biased toward mailboxes and a small window
        for (int i = 0; i < 3000; i++) begin
            int a0, a1;
            a0 = ($urandom_range(3) == 0) ? LBOX + int'($urandom_range(1)) : int'($urandom_range(31));
            a1 = ($urandom_range(3) == 0) ? LBOX + int'($urandom_range(1)) : int'($urandom_range(31));
            step(bit'($urandom_range(1)), bit'($urandom_range(1)), a0, int'($urandom_range(255)),
                 bit'($urandom_range(1)), bit'($urandom_range(1)), a1, int'($urandom_range(255)), "R1");
        end
        idle("R1");
        idle("R1");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule